// File: doc/BRIEF.md
# Variable-Length Instruction Boundary Decoder

This block sits at the front of an instruction decode pipeline for a byte-oriented, variable-length instruction encoding in 32-bit mode. Each cycle it can accept one naturally aligned 16-byte fetch block together with the byte offset where execution enters that block, such as a branch target. It marks every byte position where an instruction begins, reports the length of each marked instruction, and gives the position where the next instruction starts. When that position lies in the following block, it also reports how many bytes of the crossing instruction were already in this block.

The length logic does not walk the bytes one at a time. For every byte position it computes one length for each possible number of leading prefix bytes, all in parallel. It then keeps the candidate that matches the measured prefix run. A chain of selections links the marked starts, beginning at the entry offset. The result is the same as a strict sequential parse. Encodings that do not exist still get a boundary, because faulting on them is the job of a later stage.

Two states control the output register. `ST_EMPTY` means no result is held. `ST_LOADED` means the output registers hold the result for the block presented in the previous cycle. The transitions are:
- `ST_EMPTY` to `ST_LOADED` when `in_valid` is high.
- `ST_LOADED` stays in `ST_LOADED` when `in_valid` is high.
- `ST_LOADED` returns to `ST_EMPTY` when `in_valid` is low.

Top module: `ild_boundary_top`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises with `in_valid` low, `out_valid` is 0. During reset, `out_start`, `out_carry` and `out_tail` are 0.
- R2: `out_valid` is 1 in the cycle after a cycle with `in_valid` high, and 0 in the cycle after a cycle with `in_valid` low. All result outputs are registered, with a latency of one cycle.
- R3: Bit `in_entry` of `out_start` is set, and no bit below `in_entry` is set. Byte k of the block is `in_bytes[8k+7:8k]`.
- R4: The bytes 66, 67, F0, F2, F3, 26, 2E, 36, 3E, 64 and 65 (hex) are prefixes. Any run of them may come before the opcode. A run of 15 prefixes forms a 15-byte instruction. No length exceeds 15.
- R5: Primary opcode table (hex), where B is a 1-byte immediate and F is a full-size immediate:
  - Below 40: bit 2 clear means ModRM; low bits 100 means B; low bits 101 means F.
  - 68, A9, E8, E9 and B8–BF take F. 6A, A8, CD, EB, 70–7F and B0–B7 take B.
  - 69, 81 and C7 take ModRM+F. 6B, 80, 82, 83, C0, C1 and C6 take ModRM+B.
  - 84–8F, FE and FF take ModRM. C2 takes a 2-byte immediate.
- R6: Opcode 0F escapes to a second map, whose opcode byte follows it:
  - 40–4F, 90–9F, AF, B6, B7, BE and BF take ModRM.
  - 80–8F take F.
  - BA takes ModRM+B.
- R7: When ModRM is present, mod is bits 7:6 and rm is bits 2:0. The displacement is:
  - 1 byte for mod 01.
  - 4 bytes for mod 10.
  - 4 bytes for mod 00 with rm 101.
  - A SIB byte follows when mod is not 11 and rm is 100. With mod 00 and SIB bits 2:0 equal to 101, 4 displacement bytes are added.
- R8: A full-size immediate is 4 bytes, or 2 bytes when a 66 prefix occurs anywhere in the prefix run. The C2 immediate is always 2 bytes.
- R9: For each marked start i, `out_len[4i+3:4i]` holds its length. The next marked start is i plus that length when that sum is below 16. Unmarked positions report length 0.
- R10: Let e be the end of the last marked instruction (its start plus its length). `out_next` is e mod 16. `out_carry` is 1 when e > 16, and `out_tail` is then 16 minus that start; otherwise `out_tail` is 0. Bytes past index 15 are read as 00 when lengths are computed.
- R11: An opcode byte not listed in R5 is a 1-byte instruction. A second-map byte not listed in R6 gives a 2-byte instruction. Neither is flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A fetch block is presented this cycle |
| in_bytes | input | 128 | Fetch block, byte k at bits 8k+7:8k |
| in_entry | input | 4 | Byte offset where decoding starts |
| out_valid | output | 1 | Result registers hold a new result |
| out_start | output | 16 | One bit per byte, set where an instruction begins |
| out_len | output | 64 | Four-bit length per byte position, 0 when unmarked |
| out_next | output | 4 | Start offset of the instruction after the last marked one |
| out_carry | output | 1 | Last instruction extends into the following block |
| out_tail | output | 4 | Bytes of the crossing instruction inside this block |

## Verification
The assertions assume that `in_valid` and `in_entry` are never X or Z at a clock edge. They also assume that `in_entry` belongs to the block being presented, because the marker checks refer back to the previous cycle's offset. The bench meets this by driving every input to a defined value on the falling edge and holding it across the rising edge. Offsets are drawn only from 0 to 15, and the byte mix is weighted toward prefixes, escapes and addressing bytes, so long and crossing instructions occur often.

// File: rtl/ild_pkg.sv
package ild_pkg;

    typedef enum logic [1:0] {
        IMM_NONE,
        IMM_BYTE,
        IMM_FULL,
        IMM_WORD
    } imm_kind_e;

    typedef struct packed {
        logic      has_modrm;
        imm_kind_e imm;
    } op_class_t;

    function automatic logic is_prefix(input logic [7:0] b);
        case (b)
            8'h66, 8'h67, 8'hF0, 8'hF2, 8'hF3,
            8'h26, 8'h2E, 8'h36, 8'h3E, 8'h64, 8'h65: return 1'b1;
            default:                                   return 1'b0;
        endcase
    endfunction

    function automatic op_class_t primary_class(input logic [7:0] op);
        op_class_t c;
        c.has_modrm = 1'b0;
        c.imm       = IMM_NONE;
        if (op < 8'h40) begin
            if (!op[2])                  c.has_modrm = 1'b1;
            else if (op[1:0] == 2'b00)   c.imm = IMM_BYTE;
            else if (op[1:0] == 2'b01)   c.imm = IMM_FULL;
        end else begin
            case (op) inside
                8'h68, 8'hA9, 8'hE8, 8'hE9, [8'hB8:8'hBF]:
                    c.imm = IMM_FULL;
                8'h6A, 8'hA8, 8'hCD, 8'hEB, [8'h70:8'h7F], [8'hB0:8'hB7]:
                    c.imm = IMM_BYTE;
                8'h69, 8'h81, 8'hC7: begin
                    c.has_modrm = 1'b1;
                    c.imm       = IMM_FULL;
                end
                8'h6B, 8'h80, 8'h82, 8'h83, 8'hC0, 8'hC1, 8'hC6: begin
                    c.has_modrm = 1'b1;
                    c.imm       = IMM_BYTE;
                end
                [8'h84:8'h8F], 8'hFE, 8'hFF:
                    c.has_modrm = 1'b1;
                8'hC2:
                    c.imm = IMM_WORD;
                default: ;
            endcase
        end
        return c;
    endfunction

    function automatic op_class_t escape_class(input logic [7:0] op);
        op_class_t c;
        c.has_modrm = 1'b0;
        c.imm       = IMM_NONE;
        case (op) inside
            [8'h40:8'h4F], [8'h90:8'h9F], 8'hAF, 8'hB6, 8'hB7, 8'hBE, 8'hBF:
                c.has_modrm = 1'b1;
            [8'h80:8'h8F]:
                c.imm = IMM_FULL;
            8'hBA: begin
                c.has_modrm = 1'b1;
                c.imm       = IMM_BYTE;
            end
            default: ;
        endcase
        return c;
    endfunction

    // Length from the opcode byte onward; s[7:0] is the assumed opcode.
    function automatic logic [4:0] body_len(input logic [31:0] s, input logic opsz);
        logic       esc;
        logic [7:0] mr;
        logic [7:0] sb;
        op_class_t  c;
        logic [4:0] n;
        esc = (s[7:0] == 8'h0F);
        c   = esc ? escape_class(s[15:8]) : primary_class(s[7:0]);
        mr  = esc ? s[23:16] : s[15:8];
        sb  = esc ? s[31:24] : s[23:16];
        n   = esc ? 5'd2 : 5'd1;
        if (c.has_modrm) begin
            n = n + 5'd1;
            if (mr[7:6] != 2'b11 && mr[2:0] == 3'b100) begin
                n = n + 5'd1;
                if (mr[7:6] == 2'b00 && sb[2:0] == 3'b101) n = n + 5'd4;
            end
            case (mr[7:6])
                2'b01:   n = n + 5'd1;
                2'b10:   n = n + 5'd4;
                2'b00:   if (mr[2:0] == 3'b101) n = n + 5'd4;
                default: ;
            endcase
        end
        case (c.imm)
            IMM_BYTE: n = n + 5'd1;
            IMM_FULL: n = n + (opsz ? 5'd2 : 5'd4);
            IMM_WORD: n = n + 5'd2;
            default:  ;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/ild_byte_class.sv
module ild_byte_class (
    input  logic [7:0] byte_i,
    output logic       pfx_o,
    output logic       opsz_o
);
    import ild_pkg::*;

    assign pfx_o  = is_prefix(byte_i);
    assign opsz_o = (byte_i == 8'h66);
endmodule

// File: rtl/ild_len_calc.sv
module ild_len_calc #(
    parameter int MAX_LEN = 15,
    parameter int WIN     = MAX_LEN + 3,
    parameter int LW      = $clog2(MAX_LEN + 1)
) (
    input  logic [8*WIN-1:0]   win_bytes,
    input  logic [MAX_LEN-1:0] win_pfx,
    input  logic [MAX_LEN-1:0] win_opsz,
    output logic [LW-1:0]      len_o
);
    import ild_pkg::*;

    localparam int SW = LW + 2;

    logic [LW-1:0]      run;
    logic               stop;
    logic [MAX_LEN-1:0] seen;
    logic [SW-1:0]      hyp [MAX_LEN];
    logic [SW-1:0]      pick;

    // Length of the leading prefix run.
    always_comb begin
        run  = '0;
        stop = 1'b0;
        for (int j = 0; j < MAX_LEN; j++) begin
            if (!stop && win_pfx[j]) run = run + 1'b1;
            else                     stop = 1'b1;
        end
    end

    // seen[k]: an operand-size prefix lies among the first k bytes.
    always_comb begin
        seen[0] = 1'b0;
        for (int k = 1; k < MAX_LEN; k++) seen[k] = seen[k-1] | win_opsz[k-1];
    end

    // One hypothesis per prefix count, all evaluated at once.
    for (genvar k = 0; k < MAX_LEN; k++) begin : g_hyp
        assign hyp[k] = SW'(k) + SW'(body_len(win_bytes[8*k +: 32], seen[k]));
    end

    always_comb begin
        pick = '0;
        for (int k = 0; k < MAX_LEN; k++) begin
            if (run == LW'(k)) pick = hyp[k];
        end
        if (run == LW'(MAX_LEN) || pick > SW'(MAX_LEN)) len_o = LW'(MAX_LEN);
        else                                            len_o = pick[LW-1:0];
    end
endmodule

// File: rtl/ild_chain.sv
module ild_chain #(
    parameter int NB = 16,
    parameter int LW = 4,
    parameter int PW = $clog2(NB)
) (
    input  logic [NB*LW-1:0] lens_i,
    input  logic [PW-1:0]    entry_i,
    output logic [NB-1:0]    start_o,
    output logic [PW-1:0]    next_o,
    output logic             carry_o,
    output logic [LW-1:0]    tail_o
);
    localparam int EW = PW + 2;

    logic [NB-1:0] reach;
    logic [EW-1:0] endp;
    logic [EW-1:0] last_start;
    logic [EW-1:0] last_end;

    // Selection cascade: each reached start selects its successor.
    always_comb begin
        reach      = '0;
        endp       = '0;
        last_start = '0;
        last_end   = '0;
        for (int i = 0; i < NB; i++) begin
            if (i == int'(entry_i)) reach[i] = 1'b1;
            if (reach[i]) begin
                endp       = EW'(i) + EW'(lens_i[i*LW +: LW]);
                last_start = EW'(i);
                last_end   = endp;
                for (int j = i + 1; j < NB; j++) begin
                    if (EW'(j) == endp) reach[j] = 1'b1;
                end
            end
        end
    end

    assign start_o = reach;
    assign next_o  = last_end[PW-1:0];
    assign carry_o = (last_end > EW'(NB));
    assign tail_o  = carry_o ? LW'(EW'(NB) - last_start) : '0;
endmodule

// File: rtl/ild_boundary_top.sv
module ild_boundary_top #(
    parameter int NB      = 16,
    parameter int MAX_LEN = 15,
    localparam int PW     = $clog2(NB),
    localparam int LW     = $clog2(MAX_LEN + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [8*NB-1:0]   in_bytes,
    input  logic [PW-1:0]     in_entry,
    output logic              out_valid,
    output logic [NB-1:0]     out_start,
    output logic [NB*LW-1:0]  out_len,
    output logic [PW-1:0]     out_next,
    output logic              out_carry,
    output logic [LW-1:0]     out_tail
);
    localparam int WIN = MAX_LEN + 3;
    localparam int EXT = NB + WIN;

    typedef enum logic {
        ST_EMPTY,
        ST_LOADED
    } state_e;

    state_e state_q, state_d;

    logic [NB-1:0]     pfx, opsz;
    logic [8*EXT-1:0]  ext_bytes;
    logic [EXT-1:0]    ext_pfx, ext_opsz;
    logic [NB*LW-1:0]  lens;
    logic [NB*LW-1:0]  lens_masked;
    logic [NB-1:0]     start_c;
    logic [PW-1:0]     next_c;
    logic              carry_c;
    logic [LW-1:0]     tail_c;

    for (genvar b = 0; b < NB; b++) begin : g_cls
        ild_byte_class u_cls (
            .byte_i (in_bytes[8*b +: 8]),
            .pfx_o  (pfx[b]),
            .opsz_o (opsz[b])
        );
    end

    assign ext_bytes = {{(8*WIN){1'b0}}, in_bytes};
    assign ext_pfx   = {{WIN{1'b0}}, pfx};
    assign ext_opsz  = {{WIN{1'b0}}, opsz};

    for (genvar p = 0; p < NB; p++) begin : g_pos
        ild_len_calc #(.MAX_LEN(MAX_LEN), .WIN(WIN), .LW(LW)) u_len (
            .win_bytes (ext_bytes[8*p +: 8*WIN]),
            .win_pfx   (ext_pfx[p +: MAX_LEN]),
            .win_opsz  (ext_opsz[p +: MAX_LEN]),
            .len_o     (lens[p*LW +: LW])
        );
        assign lens_masked[p*LW +: LW] = start_c[p] ? lens[p*LW +: LW] : '0;
    end

    ild_chain #(.NB(NB), .LW(LW), .PW(PW)) u_chain (
        .lens_i  (lens),
        .entry_i (in_entry),
        .start_o (start_c),
        .next_o  (next_c),
        .carry_o (carry_c),
        .tail_o  (tail_c)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY:  if (in_valid)  state_d = ST_LOADED;
            ST_LOADED: if (!in_valid) state_d = ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_start <= '0;
            out_len   <= '0;
            out_next  <= '0;
            out_carry <= 1'b0;
            out_tail  <= '0;
        end else if (in_valid) begin
            out_start <= start_c;
            out_len   <= lens_masked;
            out_next  <= next_c;
            out_carry <= carry_c;
            out_tail  <= tail_c;
        end
    end

    assign out_valid = (state_q == ST_LOADED);
endmodule

// File: rtl/ild_checker.sv
module ild_checker #(
    parameter int NB      = 16,
    parameter int MAX_LEN = 15,
    parameter int PW      = 4,
    parameter int LW      = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [PW-1:0]    in_entry,
    input logic             out_valid,
    input logic [NB-1:0]    out_start,
    input logic [NB*LW-1:0] out_len,
    input logic             out_carry,
    input logic [LW-1:0]    out_tail
);
    localparam logic [NB-1:0] ONE = {{(NB-1){1'b0}}, 1'b1};

    AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> !out_valid); // R1

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R2

    AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R2

    AST_ENTRY_MARKED: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((out_start >> $past(in_entry)) & ONE) == ONE); // R3

    AST_NONE_BELOW: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_start & ((ONE << $past(in_entry)) - ONE)) == '0); // R3

    AST_TAIL_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_carry == (out_tail != '0))); // R10

    for (genvar i = 0; i < NB; i++) begin : g_pos
        AST_LEN_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid && !out_start[i]) |-> out_len[i*LW +: LW] == '0); // R9

        AST_LEN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid && out_start[i]) |->
            (out_len[i*LW +: LW] != '0 && out_len[i*LW +: LW] <= LW'(MAX_LEN))); // R4

        AST_SUCCESSOR: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid && out_start[i] && (i + int'(out_len[i*LW +: LW]) < NB)) |->
            ((out_start >> (i + int'(out_len[i*LW +: LW]))) & ONE) == ONE); // R9
    end
endmodule

bind ild_boundary_top ild_checker #(.NB(NB), .MAX_LEN(MAX_LEN), .PW(PW), .LW(LW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_entry  (in_entry),
    .out_valid (out_valid),
    .out_start (out_start),
    .out_len   (out_len),
    .out_carry (out_carry),
    .out_tail  (out_tail)
);

// File: tb/sim_ild_boundary_top.sv
`timescale 1ns/1ps
module sim_ild_boundary_top;
    localparam int NB = 16;
    localparam int LW = 4;
    localparam int PW = 4;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              in_valid;
    logic [8*NB-1:0]   in_bytes;
    logic [PW-1:0]     in_entry;
    logic              out_valid;
    logic [NB-1:0]     out_start;
    logic [NB*LW-1:0]  out_len;
    logic [PW-1:0]     out_next;
    logic              out_carry;
    logic [LW-1:0]     out_tail;

    always #2.5 clk = ~clk;

    ild_boundary_top u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_bytes(in_bytes),
        .in_entry(in_entry), .out_valid(out_valid), .out_start(out_start),
        .out_len(out_len), .out_next(out_next), .out_carry(out_carry),
        .out_tail(out_tail)
    );

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    logic [7:0]       blk [16];
    logic [NB-1:0]    exp_start;
    logic [NB*LW-1:0] exp_len;
    logic [PW-1:0]    exp_next;
    logic             exp_carry;
    logic [LW-1:0]    exp_tail;

    localparam logic [7:0] POOL [32] = '{
        8'h66, 8'h67, 8'hF3, 8'h2E, 8'h64, 8'h0F, 8'h00, 8'h04,
        8'h05, 8'h03, 8'h80, 8'h81, 8'h83, 8'h8B, 8'h69, 8'h6B,
        8'h68, 8'h70, 8'hB8, 8'hB0, 8'hC2, 8'hC7, 8'hE8, 8'hFF,
        8'h44, 8'h84, 8'h25, 8'hC0, 8'hAF, 8'hBA, 8'hB6, 8'h90
    };

    function automatic logic [7:0] rd(int idx);
        return (idx < 16) ? blk[idx] : 8'h00;
    endfunction

    function automatic bit ref_pfx(logic [7:0] b);
        return b inside {8'h66, 8'h67, 8'hF0, 8'hF2, 8'hF3, 8'h26, 8'h2E,
                         8'h36, 8'h3E, 8'h64, 8'h65};
    endfunction

    // imm: 0 none, 1 one byte, 2 fixed two bytes, 3 operand-size dependent
    function automatic void ref_table(input bit esc, input logic [7:0] op,
                                      output bit m, output int imm);
        m = 0; imm = 0;
        if (esc) begin
            if ((op >= 8'h40 && op <= 8'h4F) || (op >= 8'h90 && op <= 8'h9F) ||
                op inside {8'hAF, 8'hB6, 8'hB7, 8'hBE, 8'hBF}) m = 1;
            else if (op >= 8'h80 && op <= 8'h8F) imm = 3;
            else if (op == 8'hBA) begin m = 1; imm = 1; end
        end else if (op < 8'h40) begin
            if (op % 8 < 4) m = 1;
            else if (op % 8 == 4) imm = 1;
            else if (op % 8 == 5) imm = 3;
        end else if (op inside {8'h69, 8'h81, 8'hC7}) begin m = 1; imm = 3; end
        else if (op inside {8'h6B, 8'h80, 8'h82, 8'h83, 8'hC0, 8'hC1, 8'hC6}) begin m = 1; imm = 1; end
        else if ((op >= 8'h84 && op <= 8'h8F) || op == 8'hFE || op == 8'hFF) m = 1;
        else if (op inside {8'h68, 8'hA9, 8'hE8, 8'hE9} || (op >= 8'hB8)) imm = (op >= 8'hC0 && !(op inside {8'hE8, 8'hE9})) ? -1 : 3;
        else if (op inside {8'h6A, 8'hA8, 8'hCD, 8'hEB} || (op >= 8'h70 && op <= 8'h7F) ||
                 (op >= 8'hB0 && op <= 8'hB7)) imm = 1;
        else if (op == 8'hC2) imm = 2;
        // ops at C0 and above not listed above fall out of the full-immediate range
        if (!esc && imm == -1) begin
            imm = 0;
            if (op == 8'hC2) imm = 2;
            else if (op inside {8'hCD, 8'hEB}) imm = 1;
        end
    endfunction

    function automatic int ref_len(int p);
        int i = p;
        bit w16 = 0;
        bit esc = 0;
        bit m;
        int imm;
        logic [7:0] op, mr, sb;
        int n;
        while ((i - p) < 15 && ref_pfx(rd(i))) begin
            if (rd(i) == 8'h66) w16 = 1;
            i++;
        end
        if ((i - p) >= 15) return 15;
        op = rd(i); i++;
        if (op == 8'h0F) begin esc = 1; op = rd(i); i++; end
        ref_table(esc, op, m, imm);
        if (m) begin
            mr = rd(i); i++;
            if (mr[7:6] != 2'b11 && mr[2:0] == 3'b100) begin
                sb = rd(i); i++;
                if (mr[7:6] == 2'b00 && sb[2:0] == 3'b101) i += 4;
            end
            if (mr[7:6] == 2'b01) i += 1;
            else if (mr[7:6] == 2'b10) i += 4;
            else if (mr[7:6] == 2'b00 && mr[2:0] == 3'b101) i += 4;
        end
        if (imm == 1) i += 1;
        else if (imm == 2) i += 2;
        else if (imm == 3) i += (w16 ? 2 : 4);
        n = i - p;
        return (n > 15) ? 15 : n;
    endfunction

    task automatic compute_exp(input int entry);
        int p = entry;
        int l;
        exp_start = '0; exp_len = '0; exp_carry = 0; exp_tail = '0;
        while (p < 16) begin
            l = ref_len(p);
            exp_start[p] = 1'b1;
            exp_len[p*LW +: LW] = LW'(l);
            if (p + l > 16) begin exp_carry = 1; exp_tail = LW'(16 - p); end
            p += l;
        end
        exp_next = PW'(p - 16);
    endtask

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic fill(input logic [7:0] b);
        for (int i = 0; i < 16; i++) blk[i] = b;
    endtask

    // Called just after a falling edge; checks at the next falling edge.
    task automatic apply(input int entry, input string tag);
        for (int i = 0; i < 16; i++) in_bytes[8*i +: 8] = blk[i];
        in_entry = PW'(entry);
        in_valid = 1'b1;
        compute_exp(entry);
        @(negedge clk);
        chk(out_valid == 1'b1, "R2 valid", 64'(out_valid), 64'd1);
        chk(out_start == exp_start, {tag, " start"}, 64'(out_start), 64'(exp_start));
        chk(out_len == exp_len, {tag, " len"}, out_len, exp_len);
        chk({out_next, out_carry, out_tail} == {exp_next, exp_carry, exp_tail}, "R10 next/carry/tail",
            64'({out_next, out_carry, out_tail}), 64'({exp_next, exp_carry, exp_tail}));
    endtask

    task automatic idle();
        in_valid = 1'b0;
        @(negedge clk);
        chk(out_valid == 1'b0, "R2 idle", 64'(out_valid), 64'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog act=timeout exp=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; in_bytes = '0; in_entry = '0;
        fill(8'h90);
        repeat (3) @(negedge clk);
        chk(out_valid == 0 && out_start == 0 && out_carry == 0 && out_tail == 0, "R1 reset",
            64'({out_valid, out_start, out_carry}), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b0, "R1 after release", 64'(out_valid), 64'd0);

        // R3: entry offset in the middle, one-byte filler
        fill(8'h90); apply(5, "R3");
        // R4: prefixes before a register-form move
        fill(8'h90); blk[0] = 8'h66; blk[1] = 8'hF3; blk[2] = 8'h2E; blk[3] = 8'h8B; blk[4] = 8'hC0;
        apply(0, "R4");
        // R4: prefix run reaching the 15-byte cap
        fill(8'h66); apply(0, "R4 cap");
        // R5: primary immediates
        fill(8'h90); blk[0] = 8'hB8; blk[5] = 8'h6A; blk[7] = 8'h81; blk[8] = 8'hC0; blk[13] = 8'h3D;
        apply(0, "R5");
        // R8: operand-size prefix and fixed word immediate
        fill(8'h90); blk[0] = 8'h66; blk[1] = 8'hB8; blk[4] = 8'hC2; blk[7] = 8'h66; blk[8] = 8'hC2;
        apply(0, "R8");
        // R7: SIB with no base, and disp8 form
        fill(8'h90); blk[0] = 8'h8B; blk[1] = 8'h04; blk[2] = 8'h25; blk[7] = 8'h8B; blk[8] = 8'h44;
        blk[9] = 8'h24; apply(0, "R7 sib");
        // R7: disp32 forms
        fill(8'h90); blk[0] = 8'h8B; blk[1] = 8'h05; blk[6] = 8'h8B; blk[7] = 8'h80;
        apply(0, "R7 disp32");
        // R6: escape map entries
        fill(8'h90); blk[0] = 8'h0F; blk[1] = 8'h84; blk[6] = 8'h0F; blk[7] = 8'hAF; blk[8] = 8'hC0;
        blk[9] = 8'h0F; blk[10] = 8'hBA; blk[11] = 8'hE0; apply(0, "R6");
        // R11: unlisted bytes still get boundaries
        fill(8'hD6); blk[3] = 8'h0F; blk[4] = 8'h0B; apply(2, "R11");
        // R10: instruction crossing the block end, padding read as zero
        fill(8'h90); blk[14] = 8'hE8; apply(14, "R10");
        fill(8'h90); blk[15] = 8'h8B; apply(15, "R10 pad");
        idle();
        idle();

        for (int n = 0; n < 3000; n++) begin
            for (int i = 0; i < 16; i++)
                blk[i] = ($urandom % 2) ? POOL[$urandom % 32] : 8'($urandom);
            apply(int'($urandom % 16), "R9");
            if ($urandom % 8 == 0) idle();
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule